// File: doc/BRIEF.md
# Command/Data Port Buffer and Register Access Unit

This block is the processor-facing slave of a host controller. A 16-bit asynchronous bus (active-low chip select, read strobe and write strobe, two address lines) reaches an internal word buffer and two control registers only indirectly. The processor first writes a command code to the command port. It then moves 16-bit words one at a time through the data port. Each command fixes the target and the direction, and bit 7 of the code selects writing.

A byte-count register sets the length of a buffer cycle. A buffer cycle moves half that many words, and an odd count rounds up to a whole last word. Each buffer command restarts an internal word pointer at zero. Once the last word has moved, the unit goes idle and waits for the next command. The bus strobes and bus data pass through a synchronizer of at least two flip-flops inside the clock domain. The rising edge of a strobe, seen while chip select was low, ends a data phase.

A data-port strobe in the wrong direction during an active cycle sets a sticky error output. The word pointer does not move on such a strobe.

Top module: `hostbus_pio_port`

## Requirements
- R1: After reset the unit is idle, the byte count and the 32-bit setup register are zero, `dir_err` is 0 and `bus_dout` is 0.
- R2: Address value 2'b11 selects the command port and 2'b10 selects the data port. Strobes at any other address, and read strobes on the command port, have no effect. While no cycle is active, data-port strobes are ignored and `bus_dout` reads 0.
- R3: Command 16'h00A2 writes the byte-count register and 16'h0022 reads it. Each takes one data phase. Bit 7 of a command code selects the write direction.
- R4: Command 16'h00A4 writes the 32-bit setup register and 16'h0024 reads it. Each takes two data phases, the lower word first. After the second phase the unit is idle.
- R5: Command 16'h00C0 writes the buffer and 16'h0040 reads it. Each command starts at word 0 and moves successive words, one per data phase.
- R6: A buffer cycle moves ceil(count/2) words, where count is the byte-count register. Further data strobes are ignored until the next command. A count of 0 moves no word.
- R7: A data-port strobe opposite to the direction of the active command sets `dir_err`. The flag stays set until reset, and the word pointer does not advance on that strobe.
- R8: A command write during an active cycle abandons that cycle and starts the new one.
- R9: A strobe counts only if chip select was low while the strobe was low. Strobes with chip select high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 2 | Port select (11 command, 10 data) |
| bus_din | input | 16 | Write data from the processor |
| bus_dout | output | 16 | Read data to the processor |
| dir_err | output | 1 | Sticky direction-mismatch flag |

## Verification
The hardest state to reach is a strobe that the unit must ignore: one past the programmed word count, or one after a zero count. From the ports such a strobe looks the same as an ordinary write. The stimulus first fills a buffer word with a known marker. It then runs a shorter write cycle that is followed by an extra strobe, and reads the marker back through a longer read cycle. The direction-error path is exercised by a read strobe inside a write cycle, followed by a buffer read that shows the pointer did not advance.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
   localparam int unsigned WORD_W = 16;
   localparam int unsigned WR_BIT = 7;

   localparam logic [1:0] PORT_CMD = 2'b11;
   localparam logic [1:0] PORT_DAT = 2'b10;

   // base codes with the direction bit cleared
   localparam logic [WORD_W-1:0] BASE_COUNT = 16'h0022;
   localparam logic [WORD_W-1:0] BASE_SETUP = 16'h0024;
   localparam logic [WORD_W-1:0] BASE_BUF   = 16'h0040;

   typedef enum logic [1:0] {ACC_NONE, ACC_COUNT, ACC_SETUP, ACC_BUF} acc_e;
   typedef enum logic [1:0] {ST_IDLE, ST_REG, ST_BUF} seq_e;

   typedef struct packed {
      acc_e acc;
      logic wr;
   } cmd_t;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cs_n,
   input  logic         rd_n,
   input  logic         wr_n,
   input  logic [1:0]   addr,
   input  logic [W-1:0] din,
   output logic         rd_end,
   output logic         wr_end,
   output logic [1:0]   ph_addr,
   output logic [W-1:0] ph_data
);
   localparam int unsigned VW = W + 5;
   localparam int unsigned CS_B = VW - 1;
   localparam int unsigned RD_B = VW - 2;
   localparam int unsigned WR_B = VW - 3;
   localparam logic [VW-1:0] IDLE_V = {3'b111, {(W + 2){1'b0}}};

   logic [VW-1:0] raw;
   logic [VW-1:0] pipe [STAGES];
   logic [VW-1:0] cur;
   logic [VW-1:0] prev;

   assign raw = {cs_n, rd_n, wr_n, addr, din};

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= IDLE_V;
               else        pipe[0] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= IDLE_V;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   assign cur = pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_V;
      else        prev <= cur;
   end

   // phase ends when a strobe rises and chip select was low during it
   assign rd_end  = cur[RD_B] & ~prev[RD_B] & ~prev[CS_B];
   assign wr_end  = cur[WR_B] & ~prev[WR_B] & ~prev[CS_B];
   assign ph_addr = prev[W+1:W];
   assign ph_data = prev[W-1:0];
endmodule

// File: rtl/hbp_cmd_decode.sv
module hbp_cmd_decode
   import hbp_pkg::*;
(
   input  logic [WORD_W-1:0] code,
   output cmd_t              dec
);
   logic [WORD_W-1:0] base;

   always_comb begin
      base          = code;
      base[WR_BIT]  = 1'b0;
      dec.wr        = code[WR_BIT];
      if (base == BASE_COUNT)      dec.acc = ACC_COUNT;
      else if (base == BASE_SETUP) dec.acc = ACC_SETUP;
      else if (base == BASE_BUF)   dec.acc = ACC_BUF;
      else                         dec.acc = ACC_NONE;
   end
endmodule

// File: rtl/hbp_buf_mem.sv
module hbp_buf_mem #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hostbus_pio_port.sv
module hostbus_pio_port
   import hbp_pkg::*;
#(
   parameter int unsigned BUF_DEPTH   = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic [1:0]        bus_addr,
   input  logic [WORD_W-1:0] bus_din,
   output logic [WORD_W-1:0] bus_dout,
   output logic              dir_err
);
   localparam int unsigned AW = $clog2(BUF_DEPTH);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_chk_depth
      $error("BUF_DEPTH must be a power of two, at least 2");
   end
   if (CNT_W < 2 || CNT_W > WORD_W) begin : g_chk_cnt
      $error("CNT_W must lie in 2..16");
   end

   logic              rd_end, wr_end;
   logic [1:0]        ph_addr;
   logic [WORD_W-1:0] ph_data;
   cmd_t              dec, cur;
   seq_e              state;
   logic [CNT_W-1:0]  tc_q, ptr, words, words_buf;
   logic [31:0]       setup_q;
   logic              err_q;
   logic              cmd_evt, dat_wr, dat_rd, dat_evt, act_evt, dir_bad;
   logic              mem_we;
   logic [WORD_W-1:0] mem_rdata, tc_word;

   hbp_sync #(.STAGES(SYNC_STAGES), .W(WORD_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
      .addr(bus_addr), .din(bus_din), .rd_end(rd_end), .wr_end(wr_end),
      .ph_addr(ph_addr), .ph_data(ph_data)
   );

   hbp_cmd_decode u_dec (.code(ph_data), .dec(dec));

   hbp_buf_mem #(.DEPTH(BUF_DEPTH), .W(WORD_W)) u_mem (
      .clk(clk), .we(mem_we), .waddr(ptr[AW-1:0]), .wdata(ph_data),
      .raddr(ptr[AW-1:0]), .rdata(mem_rdata)
   );

   // ceil(count / 2) without a carry bit
   assign words_buf = (tc_q >> 1) + {{(CNT_W-1){1'b0}}, tc_q[0]};

   assign cmd_evt = wr_end && (ph_addr == PORT_CMD);
   assign dat_wr  = wr_end && (ph_addr == PORT_DAT);
   assign dat_rd  = rd_end && (ph_addr == PORT_DAT);
   assign dat_evt = dat_wr || dat_rd;
   assign act_evt = (state != ST_IDLE) && dat_evt;
   assign dir_bad = (dat_wr && !cur.wr) || (dat_rd && cur.wr);
   assign mem_we  = act_evt && !dir_bad && cur.wr && (cur.acc == ACC_BUF);

   if (CNT_W == WORD_W) begin : g_tc_full
      assign tc_word = tc_q;
   end else begin : g_tc_ext
      assign tc_word = {{(WORD_W-CNT_W){1'b0}}, tc_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur     <= '{acc: ACC_NONE, wr: 1'b0};
         tc_q    <= '0;
         ptr     <= '0;
         words   <= '0;
         setup_q <= '0;
         err_q   <= 1'b0;
      end else if (cmd_evt) begin
         ptr <= '0;
         cur <= dec;
         unique case (dec.acc)
            ACC_COUNT: begin state <= ST_REG; words <= ONE; end
            ACC_SETUP: begin state <= ST_REG; words <= TWO; end
            ACC_BUF: begin
               words <= words_buf;
               state <= (words_buf == '0) ? ST_IDLE : ST_BUF;
            end
            default: begin state <= ST_IDLE; words <= '0; end
         endcase
      end else if (act_evt) begin
         if (dir_bad) begin
            err_q <= 1'b1;
         end else begin
            ptr <= ptr + ONE;
            if ((ptr + ONE) == words) state <= ST_IDLE;
            if (cur.wr) begin
               unique case (cur.acc)
                  ACC_COUNT: tc_q <= ph_data[CNT_W-1:0];
                  ACC_SETUP: begin
                     if (ptr[0]) setup_q[31:16] <= ph_data;
                     else        setup_q[15:0]  <= ph_data;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      bus_dout = '0;
      if (state != ST_IDLE && !cur.wr) begin
         unique case (cur.acc)
            ACC_COUNT: bus_dout = tc_word;
            ACC_SETUP: bus_dout = ptr[0] ? setup_q[31:16] : setup_q[15:0];
            ACC_BUF:   bus_dout = mem_rdata;
            default:   bus_dout = '0;
         endcase
      end
   end

   assign dir_err = err_q;
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker
   import hbp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input seq_e             state,
   input logic [CNT_W-1:0] ptr,
   input logic [CNT_W-1:0] words,
   input logic [CNT_W-1:0] tc_q,
   input logic             err,
   input logic             cmd_evt,
   input logic             dat_evt
);
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_err_holds_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $stable(ptr));

   assert_buf_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BUF) |-> (ptr < words));

   assert_reg_phases_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REG) |-> (words <= 2 && ptr < words));

   assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_evt |=> (ptr == '0));

   assert_ptr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_evt && !dat_evt) |=> $stable(ptr));

   assert_count_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_evt |=> $stable(tc_q));
endmodule

bind hostbus_pio_port hbp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .ptr(ptr), .words(words),
   .tc_q(tc_q), .err(err_q), .cmd_evt(cmd_evt), .dat_evt(dat_evt)
);

// File: tb/hostbus_pio_port_test.sv
module hostbus_pio_port_test;
   localparam int CLK_P = 10;
   localparam logic [1:0] AC = 2'b11;
   localparam logic [1:0] AD = 2'b10;

   typedef struct packed {
      logic        rd;
      logic [1:0]  addr;
      logic [15:0] data;
      logic [15:0] exp;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      '{1'b0, AC, 16'h00A2, 16'h0, 4'd3}, // R3 count write
      '{1'b0, AD, 16'h000A, 16'h0, 4'd3},
      '{1'b0, AC, 16'h00C0, 16'h0, 4'd5}, // R5 fill 5 markers
      '{1'b0, AD, 16'hA0A0, 16'h0, 4'd5},
      '{1'b0, AD, 16'hA1A1, 16'h0, 4'd5},
      '{1'b0, AD, 16'hA2A2, 16'h0, 4'd5},
      '{1'b0, AD, 16'hA3A3, 16'h0, 4'd5},
      '{1'b0, AD, 16'hA4A4, 16'h0, 4'd5},
      '{1'b0, AC, 16'h00A2, 16'h0, 4'd6}, // R6 odd count 7 -> 4 words
      '{1'b0, AD, 16'h0007, 16'h0, 4'd6},
      '{1'b0, AC, 16'h0022, 16'h0, 4'd3},
      '{1'b1, AD, 16'h0000, 16'h0007, 4'd3}, // R3 count readback
      '{1'b0, AC, 16'h00C0, 16'h0, 4'd6},
      '{1'b0, AD, 16'h1111, 16'h0, 4'd6},
      '{1'b0, AD, 16'h2222, 16'h0, 4'd6},
      '{1'b0, AD, 16'h3333, 16'h0, 4'd6},
      '{1'b0, AD, 16'h4444, 16'h0, 4'd6},
      '{1'b0, AD, 16'h5555, 16'h0, 4'd6}, // R6 beyond count, ignored
      '{1'b0, AC, 16'h00A2, 16'h0, 4'd6},
      '{1'b0, AD, 16'h000A, 16'h0, 4'd6},
      '{1'b0, AC, 16'h0040, 16'h0, 4'd5},
      '{1'b1, AD, 16'h0, 16'h1111, 4'd5}, // R5
      '{1'b1, AD, 16'h0, 16'h2222, 4'd5},
      '{1'b1, AD, 16'h0, 16'h3333, 4'd5},
      '{1'b1, AD, 16'h0, 16'h4444, 4'd5},
      '{1'b1, AD, 16'h0, 16'hA4A4, 4'd6}, // R6 marker survived
      '{1'b1, AD, 16'h0, 16'h0000, 4'd2}, // R2 idle read is 0
      '{1'b0, AC, 16'h00A4, 16'h0, 4'd4}, // R4 setup write
      '{1'b0, AD, 16'hBEEF, 16'h0, 4'd4},
      '{1'b0, AD, 16'hCAFE, 16'h0, 4'd4},
      '{1'b0, AC, 16'h0024, 16'h0, 4'd4}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [1:0]  bus_addr = 2'b00;
   logic [15:0] bus_din = '0;
   logic [15:0] bus_dout;
   logic        dir_err;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   hostbus_pio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
      .bus_dout(bus_dout), .dir_err(dir_err)
   );

   task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic cyc(input logic cs, input logic rd, input logic [1:0] a,
                      input logic [15:0] d, output logic [15:0] got);
      @(negedge clk);
      bus_cs_n = cs; bus_addr = a; bus_din = d;
      @(negedge clk);
      if (rd) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      got = bus_dout;
      bus_rd_n = 1'b1; bus_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_cs_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      logic [15:0] g;
      cyc(1'b0, 1'b0, a, d, g);
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] g);
      cyc(1'b0, 1'b1, a, 16'h0, g);
   endtask

   initial begin
      logic [15:0] g;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {15'h0, dir_err}, 16'h0);
      check("R1", bus_dout, 16'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      wr(AC, 16'h0022); rd(AD, g); check("R1", g, 16'h0000);
      wr(AC, 16'h0024); rd(AD, g); check("R1", g, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd) begin
            rd(VEC[i].addr, g);
            n_chk++;
            if (g !== VEC[i].exp) begin
               n_bad++;
               $display("FAIL R%0d: vector %0d got %h expected %h", VEC[i].rq, i, g, VEC[i].exp);
            end
         end else begin
            wr(VEC[i].addr, VEC[i].data);
         end
      end
      // R4 lower word first, then idle
      rd(AD, g); check("R4", g, 16'hBEEF);
      rd(AD, g); check("R4", g, 16'hCAFE);
      rd(AD, g); check("R4", g, 16'h0000);

      // R9 strobe with chip select high is ignored
      wr(AC, 16'h00A2);
      cyc(1'b1, 1'b0, AD, 16'h7777, g);
      wr(AC, 16'h0022); rd(AD, g); check("R9", g, 16'h000A);

      // R2 other address and command-port read are ignored
      wr(AC, 16'h00A2);
      wr(2'b01, 16'h1234);
      rd(AC, g);
      wr(AD, 16'h0004);
      wr(AC, 16'h0022); rd(AD, g); check("R2", g, 16'h0004);
      check("R2", {15'h0, dir_err}, 16'h0);

      // R8 new command abandons a cycle
      wr(AC, 16'h00C0); wr(AD, 16'h1357);
      wr(AC, 16'h0040); rd(AD, g); check("R8", g, 16'h1357);

      // R6 zero count moves nothing
      wr(AC, 16'h00A2); wr(AD, 16'h0000);
      wr(AC, 16'h00C0); wr(AD, 16'h9999);
      wr(AC, 16'h00A2); wr(AD, 16'h0004);
      wr(AC, 16'h0040); rd(AD, g); check("R6", g, 16'h1357);

      // R7 wrong direction sets sticky flag, pointer held
      wr(AC, 16'h00C0);
      rd(AD, g);
      check("R7", {15'h0, dir_err}, 16'h0001);
      wr(AD, 16'h2468); wr(AD, 16'h3579);
      wr(AC, 16'h0040);
      rd(AD, g); check("R7", g, 16'h2468);
      rd(AD, g); check("R7", g, 16'h3579);
      check("R7", {15'h0, dir_err}, 16'h0001);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule